// File: doc/BRIEF.md
# Lockable Direct-Mapped Instruction Cache

This block is a 4 KB direct-mapped instruction cache. It sits between an instruction fetch port and a memory port that returns one 32-bit word at a time. Each line holds 4 words, so there are 256 lines. A fetch that hits is answered in the same cycle.

On a miss, a refill sequencer loads the whole line from memory. It starts with the missed word and wraps around the line. The missed word goes to the fetch port in the cycle it arrives, and the rest of the line fills in the background. A read buffer holds the line being filled, or the line most recently filled. Fetches to that line are answered from the buffer, so later words can be used before the refill ends.

Software can lock resident lines so that they stay in the cache. A miss to an index whose line is locked is served from memory without touching the array. Two global commands are provided: one invalidates every unlocked line, and the other clears every lock. Software issues these commands while no refill is running, because the block acts on them only when it is idle.

Top module: `icache_lockable`

## Requirements
- R1: A fetch that hits while no refill is running has `fetchValid` high and `fetchStall` low in the same cycle. It causes no memory request.
- R2: A fetch that misses raises `fetchStall` in its own cycle. The refill then requests the 4 words of the line, one at a time, on `memAddr`. It starts at the missed word and raises the word offset (`memAddr[3:2]`) by one modulo 4 after each `memValid`. `memReq` stays high until the fourth word has arrived.
- R3: The missed word appears on `fetchData`, with `fetchValid` high, in the same cycle as its `memValid`. This is before any other word of the line has arrived.
- R4: During a refill, a fetch to the line being filled is handled as follows. A word that has already arrived is returned in the same cycle. A word that has not arrived is returned in the cycle its `memValid` comes.
- R5: During a refill, a fetch to any other line stalls until the refill has completed.
- R6: After a refill to an unlocked index completes, the new line is resident and fetches to it hit.
- R7: The lock command (`cmdLock` with line address `cmdLine`) locks the addressed line only if that line is resident. Otherwise the command has no effect.
- R8: A miss to an index whose resident line is locked is served from memory and leaves the array unchanged. The locked line still hits afterwards.
- R9: The read buffer keeps the line of the last refill, including a refill that bypassed the array. Fetches to that line hit without any memory request.
- R10: `cmdInvalAll` makes every unlocked line non-resident and empties the read buffer. Locked lines stay resident.
- R11: `cmdUnlockAll` clears every lock. A later conflicting miss then replaces the formerly locked line.
- R12: After reset, no line is resident or locked, the read buffer is empty, and `fetchValid`, `fetchStall` and `memReq` are low.
- R13: `fetchData` returned with `fetchValid` always equals the memory word at the fetched address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchReq | input | 1 | Fetch request; the requester holds it while stalled |
| fetchAddr | input | 30 | Word address of the fetch (byte address bits 31:2) |
| fetchValid | output | 1 | `fetchData` holds the requested word this cycle |
| fetchStall | output | 1 | Fetch requested but not answered this cycle |
| fetchData | output | 32 | Instruction word |
| memReq | output | 1 | A refill word request is outstanding |
| memAddr | output | 32 | Byte address of the requested word |
| memValid | input | 1 | `memData` holds the requested word |
| memData | input | 32 | Word returned by memory |
| cmdLock | input | 1 | Lock the line at `cmdLine` if it is resident |
| cmdUnlockAll | input | 1 | Clear every lock bit |
| cmdInvalAll | input | 1 | Invalidate all unlocked lines and empty the read buffer |
| cmdLine | input | 28 | Line address for `cmdLock` (byte address bits 31:4) |

## Verification
The hardest situation to reach from the ports is a fetch that lands inside a refill. One case is a fetch for a word of the filling line that has not arrived yet. Another is a fetch for some other resident line that must wait out the refill. With random memory latency, the cycle in which such a fetch lands cannot be predicted. The bench therefore switches its memory model to a fixed, long latency. It then steps the fetch address cycle by cycle after the critical word has returned: first to a word already in the buffer, then to a word still in flight, then to a different resident line. Random fetches over a few conflicting tags, mixed with lock, unlock and invalidate commands, then cover bypass refills and read-buffer hits on bypassed lines.

// File: rtl/icache_pkg.sv
package icache_pkg;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_FILL = 1'b1
  } fillState_t;

  typedef struct packed {
    logic fillStart;
    logic wordWrite;
    logic fillDone;
    logic cmdLock;
    logic cmdUnlock;
    logic cmdInval;
  } ctlStrb_t;

endpackage

// File: rtl/icache_dpath.sv
module icache_dpath
  import icache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int NUM_LINES  = 256,
  localparam int OFF_W  = $clog2(LINE_WORDS),
  localparam int IDX_W  = $clog2(NUM_LINES),
  localparam int LINE_W = ADDR_W - 2 - OFF_W,
  localparam int TAG_W  = LINE_W - IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrb_t          strb,
  input  logic [ADDR_W-3:0] fetchAddr,
  input  logic [LINE_W-1:0] cmdLine,
  input  logic [31:0]       memData,
  input  logic [OFF_W-1:0]  fillWord,
  output logic              arrHit,
  output logic              rbHit,
  output logic              sameLine,
  output logic [OFF_W-1:0]  fetchWord,
  output logic [LINE_W-1:0] fillLine,
  output logic [31:0]       cacheData
);

  logic [LINE_W-1:0] fetchLine;
  logic [IDX_W-1:0]  fIdx, cIdx, fillIdx;
  logic [TAG_W-1:0]  fTag, cTag;

  logic [NUM_LINES-1:0] validBits, lockBits;
  logic [TAG_W-1:0]     tagArr [NUM_LINES];
  logic [31:0]          dataArr [NUM_LINES*LINE_WORDS];

  logic [LINE_W-1:0]     fillLineQ;
  logic                  fillBypass;
  logic                  rbValid;
  logic [LINE_WORDS-1:0] rbMask;
  logic [31:0]           rbWords [LINE_WORDS];
  logic                  cmdHit;

  assign fetchLine = fetchAddr[ADDR_W-3:OFF_W];
  assign fetchWord = fetchAddr[OFF_W-1:0];
  assign fIdx      = fetchLine[IDX_W-1:0];
  assign fTag      = fetchLine[LINE_W-1:IDX_W];
  assign cIdx      = cmdLine[IDX_W-1:0];
  assign cTag      = cmdLine[LINE_W-1:IDX_W];
  assign fillIdx   = fillLineQ[IDX_W-1:0];
  assign fillLine  = fillLineQ;

  assign arrHit    = validBits[fIdx] && (tagArr[fIdx] == fTag);
  assign cmdHit    = validBits[cIdx] && (tagArr[cIdx] == cTag);
  assign sameLine  = rbValid && (fillLineQ == fetchLine);
  assign rbHit     = sameLine && rbMask[fetchWord];
  assign cacheData = rbHit ? rbWords[fetchWord] : dataArr[{fIdx, fetchWord}];

  // Control state of the line array and the read buffer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      validBits  <= '0;
      lockBits   <= '0;
      rbValid    <= 1'b0;
      rbMask     <= '0;
      fillLineQ  <= '0;
      fillBypass <= 1'b0;
    end else begin
      if (strb.fillStart) begin
        fillLineQ  <= fetchLine;
        fillBypass <= lockBits[fIdx];
        rbValid    <= 1'b1;
        rbMask     <= '0;
        if (!lockBits[fIdx]) validBits[fIdx] <= 1'b0;
      end
      if (strb.wordWrite) rbMask[fillWord] <= 1'b1;
      if (strb.fillDone && !fillBypass) validBits[fillIdx] <= 1'b1;
      if (strb.cmdInval) begin
        validBits <= validBits & lockBits;
        rbValid   <= 1'b0;
      end
      if (strb.cmdLock && cmdHit) lockBits[cIdx] <= 1'b1;
      if (strb.cmdUnlock) lockBits <= '0;
    end
  end

  // Storage without reset
  always_ff @(posedge clk) begin
    if (strb.wordWrite) begin
      rbWords[fillWord] <= memData;
      if (!fillBypass) dataArr[{fillIdx, fillWord}] <= memData;
    end
    if (strb.fillDone && !fillBypass) tagArr[fillIdx] <= fillLineQ[LINE_W-1:IDX_W];
  end

  // R7: a lock bit is only ever held by a resident line
  a_r7_lock_implies_valid: assert property (@(posedge clk) disable iff (!rstN)
    $countones(lockBits & ~validBits) == 0);

  // R6: a completed allocating refill leaves its line valid
  a_r6_fill_makes_valid: assert property (@(posedge clk) disable iff (!rstN)
    strb.fillDone && !fillBypass |=> validBits[fillIdx]);

  // R10: after invalidate only locked lines remain valid
  a_r10_inval_clears: assert property (@(posedge clk) disable iff (!rstN)
    strb.cmdInval && !strb.cmdUnlock |=> (validBits & ~lockBits) == '0 && !rbValid);

  // R11: unlock-all leaves no lock behind
  a_r11_unlock_clears: assert property (@(posedge clk) disable iff (!rstN)
    strb.cmdUnlock |=> lockBits == '0);

  // R8: a bypass refill never changes the valid bit of its index
  a_r8_bypass_keeps_line: assert property (@(posedge clk) disable iff (!rstN)
    strb.wordWrite && fillBypass |=> $stable(validBits[fillIdx]));

endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
  import icache_pkg::*;
#(
  parameter int LINE_WORDS = 4,
  localparam int OFF_W = $clog2(LINE_WORDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fetchReq,
  input  logic             cmdLockIn,
  input  logic             cmdUnlockIn,
  input  logic             cmdInvalIn,
  input  logic             memValid,
  input  logic             arrHit,
  input  logic             rbHit,
  input  logic             sameLine,
  input  logic [OFF_W-1:0] fetchWord,
  output ctlStrb_t         strb,
  output logic [OFF_W-1:0] fillWord,
  output logic             memReq,
  output logic             fetchValid,
  output logic             fetchStall,
  output logic             useMem
);

  localparam logic [OFF_W-1:0] LAST = OFF_W'(LINE_WORDS - 1);

  fillState_t       state;
  logic [OFF_W-1:0] startWord, cnt;
  logic             idle, cmdAny, serve;

  assign idle     = (state == S_IDLE);
  assign cmdAny   = cmdLockIn || cmdUnlockIn || cmdInvalIn;
  assign fillWord = startWord + cnt;
  assign memReq   = !idle;

  assign useMem     = !idle && memValid && sameLine && (fetchWord == fillWord);
  assign serve      = rbHit || (idle && arrHit) || useMem;
  assign fetchValid = fetchReq && serve;
  assign fetchStall = fetchReq && !serve;

  always_comb begin
    strb           = '0;
    strb.fillStart = idle && fetchReq && !serve && !cmdAny;
    strb.wordWrite = !idle && memValid;
    strb.fillDone  = !idle && memValid && (cnt == LAST);
    strb.cmdLock   = idle && cmdLockIn;
    strb.cmdUnlock = idle && cmdUnlockIn;
    strb.cmdInval  = idle && cmdInvalIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      startWord <= '0;
      cnt       <= '0;
    end else if (strb.fillStart) begin
      state     <= S_FILL;
      startWord <= fetchWord;
      cnt       <= '0;
    end else if (strb.wordWrite) begin
      cnt <= cnt + 1'b1;
      if (strb.fillDone) state <= S_IDLE;
    end
  end

  // R2: a request stays up, on the same word, until memory answers
  a_r2_req_held: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memValid |=> memReq && $stable(fillWord));

  // R2: the requested word steps by one and wraps within the line
  a_r2_word_wraps: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memValid && !strb.fillDone |=> fillWord == OFF_W'($past(fillWord) + 1'b1));

  // R5: another line waits while a refill runs
  a_r5_other_line_waits: assert property (@(posedge clk) disable iff (!rstN)
    memReq && fetchReq && !sameLine |-> fetchStall);

  // R1: no refill starts while commands are pending
  a_r1_no_start_on_cmd: assert property (@(posedge clk) disable iff (!rstN)
    idle && cmdAny |=> !memReq);

endmodule

// File: rtl/icache_lockable.sv
module icache_lockable
  import icache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int NUM_LINES  = 256,
  localparam int OFF_W  = $clog2(LINE_WORDS),
  localparam int LINE_W = ADDR_W - 2 - OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchReq,
  input  logic [ADDR_W-3:0] fetchAddr,
  output logic              fetchValid,
  output logic              fetchStall,
  output logic [31:0]       fetchData,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memValid,
  input  logic [31:0]       memData,
  input  logic              cmdLock,
  input  logic              cmdUnlockAll,
  input  logic              cmdInvalAll,
  input  logic [LINE_W-1:0] cmdLine
);

  ctlStrb_t          strb;
  logic              arrHit, rbHit, sameLine, useMem;
  logic [OFF_W-1:0]  fetchWord, fillWord;
  logic [LINE_W-1:0] fillLine;
  logic [31:0]       cacheData;

  icache_ctrl #(.LINE_WORDS(LINE_WORDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .fetchReq(fetchReq),
    .cmdLockIn(cmdLock), .cmdUnlockIn(cmdUnlockAll), .cmdInvalIn(cmdInvalAll),
    .memValid(memValid), .arrHit(arrHit), .rbHit(rbHit), .sameLine(sameLine),
    .fetchWord(fetchWord), .strb(strb), .fillWord(fillWord), .memReq(memReq),
    .fetchValid(fetchValid), .fetchStall(fetchStall), .useMem(useMem)
  );

  icache_dpath #(.ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS), .NUM_LINES(NUM_LINES)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .fetchAddr(fetchAddr), .cmdLine(cmdLine),
    .memData(memData), .fillWord(fillWord), .arrHit(arrHit), .rbHit(rbHit),
    .sameLine(sameLine), .fetchWord(fetchWord), .fillLine(fillLine), .cacheData(cacheData)
  );

  assign fetchData = useMem ? memData : cacheData;
  assign memAddr   = {fillLine, fillWord, 2'b00};

endmodule

// File: tb/icache_lockable_bench.sv
module icache_lockable_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fetchReq = 1'b0;
  logic [29:0] fetchAddr = '0;
  logic        fetchValid, fetchStall, memReq;
  logic [31:0] fetchData, memAddr;
  logic        memValid = 1'b0;
  logic [31:0] memData = '0;
  logic        cmdLock = 1'b0, cmdUnlockAll = 1'b0, cmdInvalAll = 1'b0;
  logic [27:0] cmdLine = '0;

  icache_lockable u_icache_lockable (
    .clk(clk), .rstN(rstN), .fetchReq(fetchReq), .fetchAddr(fetchAddr),
    .fetchValid(fetchValid), .fetchStall(fetchStall), .fetchData(fetchData),
    .memReq(memReq), .memAddr(memAddr), .memValid(memValid), .memData(memData),
    .cmdLock(cmdLock), .cmdUnlockAll(cmdUnlockAll), .cmdInvalAll(cmdInvalAll),
    .cmdLine(cmdLine)
  );

  always #10 clk = ~clk;

  int total = 0;
  int bad = 0;

  // reference state
  bit          mValid [256];
  bit          mLock  [256];
  logic [19:0] mTag   [256];
  logic [27:0] rbLine = '0;
  bit          rbOk = 0;

  // memory model
  logic [31:0] logArr [64];
  int          logN = 0;
  int          waitCnt = 0;
  bit          useRand = 1;
  int          fixedLat = 3;

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'hC3A5_0F1E;
  endfunction

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      memValid = 1'b0;
      if (memReq) begin
        if (waitCnt > 0) waitCnt--;
        else begin
          memValid = 1'b1;
          memData = memWord(memAddr);
          logArr[logN % 64] = memAddr;
          logN++;
          waitCnt = useRand ? int'($urandom_range(0, 2)) : fixedLat;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    finishRun();
  end

  function automatic bit predictHit(input logic [31:0] a);
    return (rbOk && rbLine == a[31:4]) || (mValid[a[11:4]] && mTag[a[11:4]] == a[31:12]);
  endfunction

  task automatic modelFill(input logic [31:0] a);
    if (!mLock[a[11:4]]) begin
      mValid[a[11:4]] = 1;
      mTag[a[11:4]] = a[31:12];
    end
    rbLine = a[31:4];
    rbOk = 1;
  endtask

  // one fetch, fill awaited; hitSeen tells whether it was answered at once
  task automatic doFetch(input logic [31:0] a, output bit hitSeen);
    bit predHit;
    int st;
    int cyc;
    predHit = predictHit(a);
    @(negedge clk);
    fetchReq = 1'b1;
    fetchAddr = a[31:2];
    st = logN;
    #1;
    hitSeen = fetchValid;
    check(fetchValid == predHit, "R1 hit/miss", fetchValid, predHit);
    if (fetchValid) begin
      check(fetchData == memWord(a), "R13 hit data", fetchData, memWord(a));
      @(negedge clk);
      fetchReq = 1'b0;
      #1;
      check(memReq == 1'b0, "R1 no memory request", memReq, 0);
    end else begin
      check(fetchStall == 1'b1, "R2 stall on miss", fetchStall, 1);
      cyc = 0;
      while (!fetchValid && cyc < 60) begin
        @(negedge clk);
        #1;
        cyc++;
      end
      check(fetchValid == 1'b1, "R3 critical word returned", fetchValid, 1);
      check(logN - st == 1, "R3 returned with first word", logN - st, 1);
      check(fetchData == memWord(a), "R13 miss data", fetchData, memWord(a));
      @(negedge clk);
      fetchReq = 1'b0;
      #1;
      cyc = 0;
      while (memReq && cyc < 60) begin
        @(negedge clk);
        #1;
        cyc++;
      end
      check(logN - st == 4, "R2 four words per line", logN - st, 4);
      for (int k = 0; k < 4; k++) begin
        logic [31:0] expA;
        expA = {a[31:4], 2'(a[3:2] + 2'(k)), 2'b00};
        check(logArr[(st + k) % 64] == expA, "R2 wrap order", logArr[(st + k) % 64], expA);
      end
      modelFill(a);
    end
  endtask

  task automatic doCmd(input int kind, input logic [31:0] a);
    @(negedge clk);
    fetchReq = 1'b0;
    cmdLine = a[31:4];
    cmdLock = (kind == 0);
    cmdInvalAll = (kind == 1);
    cmdUnlockAll = (kind == 2);
    @(negedge clk);
    cmdLock = 1'b0;
    cmdInvalAll = 1'b0;
    cmdUnlockAll = 1'b0;
    if (kind == 0) begin
      if (mValid[a[11:4]] && mTag[a[11:4]] == a[31:12]) mLock[a[11:4]] = 1;
    end else if (kind == 1) begin
      for (int i = 0; i < 256; i++) if (!mLock[i]) mValid[i] = 0;
      rbOk = 0;
    end else begin
      for (int i = 0; i < 256; i++) mLock[i] = 0;
    end
  endtask

  localparam logic [31:0] A_ADDR  = 32'h0000_1238;
  localparam logic [31:0] A2_ADDR = 32'h0005_1238;
  localparam logic [31:0] B_ADDR  = 32'h0000_2454;
  localparam logic [31:0] D_ADDR  = 32'h0003_3450;

  initial begin
    bit h;
    int st;
    int cyc;
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) begin
      mValid[i] = 0;
      mLock[i] = 0;
      mTag[i] = '0;
    end
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    #1;
    check(fetchValid == 0 && fetchStall == 0 && memReq == 0, "R12 idle after reset",
          {fetchValid, fetchStall, memReq}, 0);

    // cold miss mid-line, then rest of line hits
    doFetch(A_ADDR, h);
    check(h == 0, "R12 cache empty after reset", h, 0);
    for (int w = 0; w < 4; w++) begin
      doFetch({A_ADDR[31:4], 2'(w), 2'b00}, h);
      check(h == 1, "R6 line resident after fill", h, 1);
    end

    // fetches stepped through a slow refill
    useRand = 0;
    @(negedge clk);
    fetchReq = 1'b1;
    fetchAddr = B_ADDR[31:2];
    st = logN;
    #1;
    check(fetchStall == 1, "R2 stall on miss B", fetchStall, 1);
    cyc = 0;
    while (!fetchValid && cyc < 60) begin
      @(negedge clk);
      #1;
      cyc++;
    end
    check(fetchData == memWord(B_ADDR), "R3 critical word B", fetchData, memWord(B_ADDR));
    @(negedge clk);
    #1;
    check(fetchValid == 1 && memReq == 1, "R4 arrived word from buffer", {fetchValid, memReq}, 3);
    check(fetchData == memWord(B_ADDR), "R4 buffer data", fetchData, memWord(B_ADDR));
    @(negedge clk);
    fetchAddr = B_ADDR[31:2] + 30'd1;
    #1;
    check(fetchStall == 1, "R4 word in flight stalls", fetchStall, 1);
    cyc = 0;
    while (!fetchValid && cyc < 60) begin
      @(negedge clk);
      #1;
      cyc++;
    end
    check(memValid == 1 && logArr[(logN - 1) % 64] == B_ADDR + 32'd4, "R4 returned on arrival",
          logArr[(logN - 1) % 64], B_ADDR + 32'd4);
    check(fetchData == memWord(B_ADDR + 32'd4), "R4 forwarded data", fetchData, memWord(B_ADDR + 32'd4));
    @(negedge clk);
    fetchAddr = A_ADDR[31:2];
    #1;
    check(fetchStall == 1 && memReq == 1, "R5 other line stalls", {fetchStall, memReq}, 3);
    cyc = 0;
    while (!fetchValid && cyc < 60) begin
      @(negedge clk);
      #1;
      cyc++;
    end
    check(memReq == 0 && logN - st == 4, "R5 served after fill", logN - st, 4);
    check(fetchData == memWord(A_ADDR), "R13 data after wait", fetchData, memWord(A_ADDR));
    @(negedge clk);
    fetchReq = 1'b0;
    modelFill(B_ADDR);
    useRand = 1;

    // locking and bypass
    doCmd(0, A_ADDR);
    doFetch(A2_ADDR, h);
    check(h == 0, "R8 conflicting miss", h, 0);
    doFetch(A2_ADDR, h);
    check(h == 1, "R9 bypassed line in buffer", h, 1);
    doFetch(A_ADDR, h);
    check(h == 1, "R8 locked line kept", h, 1);

    // lock on a non-resident line does nothing
    doCmd(0, D_ADDR);
    doFetch(D_ADDR, h);
    doFetch(B_ADDR, h);
    check(h == 0, "R7 no lock took effect", h, 0);
    doFetch(D_ADDR, h);
    check(h == 0, "R7 line replaced", h, 0);

    // invalidate
    doCmd(1, 0);
    doFetch(A_ADDR, h);
    check(h == 1, "R10 locked line survives", h, 1);
    doFetch(D_ADDR, h);
    check(h == 0, "R10 unlocked line and buffer cleared", h, 0);

    // unlock all
    doCmd(2, 0);
    doFetch(A2_ADDR, h);
    check(h == 0, "R11 conflicting miss", h, 0);
    doFetch(A_ADDR, h);
    check(h == 0, "R11 old line replaced", h, 0);

    // random mix
    for (int n = 0; n < 600; n++) begin
      int r;
      logic [31:0] a;
      r = int'($urandom_range(0, 99));
      a = {20'h00100 + 20'($urandom_range(0, 2)), 8'h10 + 8'($urandom_range(0, 2)),
           2'($urandom_range(0, 3)), 2'b00};
      if (r < 8) doCmd(0, a);
      else if (r < 10) doCmd(1, a);
      else if (r < 12) doCmd(2, a);
      else doFetch(a, h);
    end

    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule